// File: doc/BRIEF.md
# User-Mode Dummy-Cycle Snooper

This block follows the byte stream that software pushes toward a serial flash in user mode, once a chip select has been taken low. It treats the first write after the select as the command opcode and looks the opcode up in a small table to learn how many dummy bytes the command needs. It then counts the address bytes that follow. When software issues the write that would carry its own dummy bytes, the block swallows that write. In its place it sends the required number of copies of the dummy-data value to the shifter, one byte per clock.

Software can therefore drive fast-read and multi-I/O read commands without knowing their dummy lengths. A control-register write carrying the chip-select stop bit arms the tracker when the bit is clear and turns it off when the bit is set. Reads and the fixed-mode sequencer sit outside this block.

The tracker is a four-state machine. In **OFF** writes pass through untouched. In **OPCODE** (armed) the block waits for the opcode. In **ADDR** it counts address bytes. In **INJECT** it emits dummy bytes while holding the write bus. The transitions are:
- *arm*: a control write with stop clear, from any state, goes to OPCODE.
- *disarm*: a control write with stop set, from any state, goes to OFF.
- *no_dummy*: OPCODE goes to OFF on a READ or unknown opcode.
- *track*: OPCODE goes to ADDR on an opcode that needs dummies.
- *count*: ADDR stays in ADDR while address bytes are still due.
- *swallow*: ADDR goes to INJECT on the dummy write.
- *drained*: INJECT goes to OFF after the last dummy byte.

Top module: `dummy_snoop`

## Requirements
- R1: After reset the block is OFF: `wr_ready` is 1, `inj_valid` is 0, and no accepted write is consumed until the block is armed.
- R2: A cycle with `cs_ctl_wr` high holds `wr_ready` low. From the next cycle the block is armed (waiting for an opcode) if `cs_ctl_stop` was 0, and OFF if it was 1, whatever state it was in before.
- R3: The first write accepted while armed supplies its opcode in `wr_lsb`. The opcodes 0x03 and 0x13, and any opcode missing from the table, return the block to OFF. That write and every later write up to the next arm are not consumed.
- R4: Dummy lengths in units: 0x0B, 0x0C, 0x3B, 0x3C, 0x6B, 0x6C, 0xBB and 0xBC need 1 unit, and 0xEB and 0xEC need 3 units. The number of injected bytes is units × `DUMMY_PER_UNIT` (8 by default).
- R5: The address width is 3 bytes when `addr4` is 0 and 4 bytes when it is 1. A byte index starts at 0 on arming and advances by `wr_size` (a byte count from 1 to 4) on each accepted write, the opcode write included.
- R6: An accepted write whose index is at least address width + 1 at acceptance has `wr_consume` high in its acceptance cycle. No other write is consumed, and `wr_consume` is high only on an accepted write.
- R7: From the cycle after the consumed write, `inj_valid` is high for exactly the number of cycles R4 gives. During those cycles `inj_byte` equals `dummy_data` and `wr_ready` is 0. The block is then OFF.
- R8: A control write during injection ends it: `inj_valid` is 0 from the next cycle, and R2 decides the new state.
- R9: A single write that packs the opcode and address bytes advances the index by its full size. For example, a 4-byte opcode write in 3-byte mode makes the very next write the consumed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_ctl_wr | input | 1 | Chip-select control register write strobe |
| cs_ctl_stop | input | 1 | Stop bit value carried by that control write |
| addr4 | input | 1 | 1 selects 4-byte addressing |
| dummy_data | input | 8 | Byte value sent during injection |
| wr_valid | input | 1 | User-mode write offered |
| wr_lsb | input | 8 | Least significant byte of the offered write |
| wr_size | input | 3 | Byte count of the offered write (1..4) |
| wr_ready | output | 1 | Write accepted this cycle when high with `wr_valid` |
| wr_consume | output | 1 | Accepted write is swallowed and not sent to the shifter |
| inj_valid | output | 1 | Injected dummy byte valid this cycle |
| inj_byte | output | 8 | Injected dummy byte |

## Verification
The bench builds the block with its default parameters: a 4-byte write bus, 3- and 4-byte address widths and 8 bytes per dummy unit. With these values the 3-unit quad I/O opcodes produce a 24-byte run that is long enough to interrupt partway, and index overshoot becomes possible when a wide address write jumps past the threshold. Mixed write sizes, both address widths, pass-through opcodes, disarm and re-arm mid-command, and an aborted run are all reachable within a few hundred cycles.

// File: rtl/dsnoop_pkg.sv
package dsnoop_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_OPCODE = 2'd1,
        ST_ADDR   = 2'd2,
        ST_INJECT = 2'd3
    } snoop_state_e;

    localparam int N_OPS     = 12;
    localparam int UNIT_W    = 2;
    localparam int MAX_UNITS = 3;

    // entry 0 at the least significant end
    localparam logic [N_OPS*8-1:0] OP_CODES = {
        8'hEC, 8'hEB, 8'hBC, 8'hBB, 8'h6C, 8'h6B,
        8'h3C, 8'h3B, 8'h0C, 8'h0B, 8'h13, 8'h03
    };

    localparam logic [N_OPS*UNIT_W-1:0] OP_UNITS = {
        2'd3, 2'd3, 2'd1, 2'd1, 2'd1, 2'd1,
        2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0
    };

endpackage

// File: rtl/dsnoop_op_lut.sv
module dsnoop_op_lut
    import dsnoop_pkg::*;
(
    input  logic [7:0]        opcode,
    output logic [UNIT_W-1:0] units
);

    logic [N_OPS-1:0] hit;

    for (genvar g = 0; g < N_OPS; g++) begin : g_entry
        assign hit[g] = (opcode == OP_CODES[g*8 +: 8]);
    end

    always_comb begin
        units = '0;
        for (int i = 0; i < N_OPS; i++) begin
            if (hit[i]) begin
                units = units | OP_UNITS[i*UNIT_W +: UNIT_W];
            end
        end
    end

endmodule

// File: rtl/dsnoop_inject.sv
module dsnoop_inject #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             abort,
    output logic             active,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (abort) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dsnoop_fsm.sv
module dsnoop_fsm
    import dsnoop_pkg::*;
#(
    parameter int SIZE_W     = 3,
    parameter int IDX_W      = 4,
    parameter int ADDR_SHORT = 3,
    parameter int ADDR_LONG  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_stop,
    input  logic              acc,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [UNIT_W-1:0] op_units,
    input  logic              addr4,
    input  logic              inj_last,
    output snoop_state_e      state,
    output logic              consume,
    output logic              start_inj,
    output logic [UNIT_W-1:0] units_q
);

    localparam logic [IDX_W-1:0] THR_SHORT = IDX_W'(ADDR_SHORT + 1);
    localparam logic [IDX_W-1:0] THR_LONG  = IDX_W'(ADDR_LONG + 1);

    snoop_state_e      state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [UNIT_W-1:0] units_d;
    logic [IDX_W-1:0]  thr;
    logic              at_dummy;

    assign thr      = addr4 ? THR_LONG : THR_SHORT;
    assign at_dummy = (idx_q >= thr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            idx_q   <= '0;
            units_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            units_q <= units_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        units_d = units_q;
        if (ctl_wr) begin
            state_d = ctl_stop ? ST_OFF : ST_OPCODE;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                end
                ST_OPCODE: begin
                    if (acc) begin
                        if (op_units == '0) begin
                            state_d = ST_OFF;
                        end else begin
                            state_d = ST_ADDR;
                            idx_d   = IDX_W'(acc_size);
                            units_d = op_units;
                        end
                    end
                end
                ST_ADDR: begin
                    if (acc) begin
                        if (at_dummy) begin
                            state_d = ST_INJECT;
                        end else begin
                            idx_d = idx_q + IDX_W'(acc_size);
                        end
                    end
                end
                ST_INJECT: begin
                    if (inj_last) begin
                        state_d = ST_OFF;
                    end
                end
            endcase
        end
    end

    always_comb begin
        consume   = 1'b0;
        start_inj = 1'b0;
        unique case (state_q)
            ST_ADDR: begin
                consume   = acc && at_dummy && !ctl_wr;
                start_inj = consume;
            end
            default: begin
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/dummy_snoop.sv
module dummy_snoop
    import dsnoop_pkg::*;
#(
    parameter int BUS_BYTES      = 4,
    parameter int ADDR_SHORT     = 3,
    parameter int ADDR_LONG      = 4,
    parameter int DUMMY_PER_UNIT = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cs_ctl_wr,
    input  logic                             cs_ctl_stop,
    input  logic                             addr4,
    input  logic [7:0]                       dummy_data,
    input  logic                             wr_valid,
    input  logic [7:0]                       wr_lsb,
    input  logic [$clog2(BUS_BYTES+1)-1:0]   wr_size,
    output logic                             wr_ready,
    output logic                             wr_consume,
    output logic                             inj_valid,
    output logic [7:0]                       inj_byte
);

    localparam int SIZE_W = $clog2(BUS_BYTES + 1);
    localparam int IDX_W  = $clog2(ADDR_LONG + BUS_BYTES + 2);
    localparam int CNT_W  = $clog2(MAX_UNITS * DUMMY_PER_UNIT + 1);

    snoop_state_e      state;
    logic [UNIT_W-1:0] op_units;
    logic [UNIT_W-1:0] units_q;
    logic              acc;
    logic              start_inj;
    logic              inj_active;
    logic              inj_last;
    logic [CNT_W-1:0]  load_val;

    assign wr_ready = !cs_ctl_wr && (state != ST_INJECT);
    assign acc      = wr_valid && wr_ready;
    assign load_val = CNT_W'(int'(units_q) * DUMMY_PER_UNIT);

    dsnoop_op_lut u_lut (
        .opcode (wr_lsb),
        .units  (op_units)
    );

    dsnoop_fsm #(
        .SIZE_W     (SIZE_W),
        .IDX_W      (IDX_W),
        .ADDR_SHORT (ADDR_SHORT),
        .ADDR_LONG  (ADDR_LONG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (cs_ctl_wr),
        .ctl_stop  (cs_ctl_stop),
        .acc       (acc),
        .acc_size  (wr_size),
        .op_units  (op_units),
        .addr4     (addr4),
        .inj_last  (inj_last),
        .state     (state),
        .consume   (wr_consume),
        .start_inj (start_inj),
        .units_q   (units_q)
    );

    dsnoop_inject #(
        .CNT_W (CNT_W)
    ) u_inj (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_inj),
        .load_val (load_val),
        .abort    (cs_ctl_wr),
        .active   (inj_active),
        .last     (inj_last)
    );

    assign inj_valid = (state == ST_INJECT) && inj_active;
    assign inj_byte  = inj_valid ? dummy_data : 8'h00;

endmodule

// File: rtl/dummy_snoop_chk.sv
module dummy_snoop_chk #(
    parameter int DUMMY_PER_UNIT = 8
) (
    input logic clk,
    input logic rst_n,
    input logic cs_ctl_wr,
    input logic wr_valid,
    input logic wr_ready,
    input logic wr_consume,
    input logic inj_valid
);

    localparam int MAX_RUN = dsnoop_pkg::MAX_UNITS * DUMMY_PER_UNIT;
    localparam int RUN_W   = $clog2(MAX_RUN + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (inj_valid) begin
            if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R7
    inj_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> !wr_ready);

    // R2
    ctl_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ctl_wr |-> !wr_ready);

    // R6
    consume_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_consume |-> (wr_valid && wr_ready));

    // R7
    inj_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_consume |=> inj_valid);

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ctl_wr |=> !inj_valid);

    // R7
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_q) <= MAX_RUN);

endmodule

bind dummy_snoop dummy_snoop_chk #(.DUMMY_PER_UNIT(DUMMY_PER_UNIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_ctl_wr  (cs_ctl_wr),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_consume (wr_consume),
    .inj_valid  (inj_valid)
);

// File: tb/dummy_snoop_test.sv
module dummy_snoop_test;

    localparam int CLK_PERIOD = 10;
    localparam int DPU        = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_ctl_wr = 1'b0;
    logic       cs_ctl_stop = 1'b1;
    logic       addr4 = 1'b0;
    logic [7:0] dummy_data = 8'h00;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_lsb = 8'h00;
    logic [2:0] wr_size = 3'd1;
    logic       wr_ready, wr_consume, inj_valid;
    logic [7:0] inj_byte;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    bit cyc_fail = 1'b0;
    int run_len  = 0;

    bit exp_cons[$];
    int exp_run[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dummy_snoop uut (
        .clk(clk), .rst_n(rst_n), .cs_ctl_wr(cs_ctl_wr), .cs_ctl_stop(cs_ctl_stop),
        .addr4(addr4), .dummy_data(dummy_data), .wr_valid(wr_valid), .wr_lsb(wr_lsb),
        .wr_size(wr_size), .wr_ready(wr_ready), .wr_consume(wr_consume),
        .inj_valid(inj_valid), .inj_byte(inj_byte)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // driver: one write, expected consume flag and optional run length queued
    task automatic put(input logic [7:0] b, input int sz, input bit cons, input int run);
        exp_cons.push_back(cons);
        if (cons) exp_run.push_back(run);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_lsb = b; wr_size = 3'(sz);
        do @(negedge clk); while (!wr_ready);
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic ctl(input bit stop);
        @(posedge clk); #1;
        cs_ctl_wr = 1'b1; cs_ctl_stop = stop;
        @(posedge clk); #1;
        cs_ctl_wr = 1'b0;
    endtask

    task automatic drain();
        while (inj_valid || !wr_ready) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wr_valid && wr_ready) begin
                if (exp_cons.size() == 0) begin
                    check(1'b0, "R6 unexpected write", 1, 0);
                end else begin
                    bit e;
                    e = exp_cons.pop_front();
                    check(wr_consume == e, "R6 consume flag", wr_consume, e);
                end
            end else begin
                check(!wr_consume, "R6 consume without accept", wr_consume, 0);
            end
            if (cs_ctl_wr) check(!wr_ready, "R2 ready during control write", wr_ready, 0);
            if (inj_valid) begin
                run_len++;
                check(inj_byte == dummy_data, "R7 dummy byte", inj_byte, dummy_data);
                check(!wr_ready, "R7 stall", wr_ready, 0);
            end else if (run_len > 0) begin
                if (exp_run.size() == 0) begin
                    check(1'b0, "R7 unexpected run", run_len, 0);
                end else begin
                    int e;
                    e = exp_run.pop_front();
                    check(run_len == e, "R7 R4 run length", run_len, e);
                end
                run_len = 0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
        check(inj_valid == 1'b0, "R1 inj", inj_valid, 0);
        check(wr_consume == 1'b0, "R1 consume", wr_consume, 0);
        // R1: unarmed stream passes
        put(8'h0B, 1, 0, 0); put(8'h00, 3, 0, 0); put(8'hFF, 1, 0, 0); put(8'h11, 4, 0, 0);

        // R4 R5 R7: quad I/O, 3-byte address, 24 dummies
        dummy_data = 8'hA5;
        ctl(0);
        put(8'hEB, 1, 0, 0); put(8'h01, 1, 0, 0); put(8'h02, 1, 0, 0); put(8'h03, 1, 0, 0);
        put(8'hFF, 1, 1, 3*DPU);
        put(8'h55, 4, 0, 0); // R7: off afterwards
        drain();

        // R5: fast read, 4-byte address in 2+2
        addr4 = 1'b1; dummy_data = 8'h3C;
        ctl(0);
        put(8'h0C, 1, 0, 0); put(8'h10, 2, 0, 0); put(8'h20, 2, 0, 0);
        put(8'h00, 1, 1, DPU);
        put(8'h77, 1, 0, 0);
        drain();

        // R5: 4-byte mode, 3 address bytes not enough
        ctl(0);
        put(8'h3C, 1, 0, 0); put(8'h10, 3, 0, 0); put(8'h20, 1, 0, 0);
        put(8'h00, 1, 1, DPU);
        drain();
        addr4 = 1'b0;

        // R9: opcode packed with address, next write swallowed
        dummy_data = 8'h5A;
        ctl(0);
        put(8'h3B, 4, 0, 0); put(8'h99, 2, 1, DPU);
        drain();

        // R5 overshoot: 1 + 4 then dummy
        ctl(0);
        put(8'hBC, 1, 0, 0); put(8'h12, 4, 0, 0); put(8'h34, 1, 1, DPU);
        drain();

        // R3: READ opcodes and unknown opcode pass through
        ctl(0);
        put(8'h03, 1, 0, 0); put(8'h00, 1, 0, 0); put(8'h00, 1, 0, 0); put(8'h00, 1, 0, 0);
        put(8'h00, 1, 0, 0); put(8'h00, 1, 0, 0);
        ctl(0);
        put(8'h13, 4, 0, 0); put(8'h00, 4, 0, 0); put(8'h00, 4, 0, 0);
        ctl(0);
        put(8'h55, 1, 0, 0); put(8'h00, 3, 0, 0); put(8'h00, 1, 0, 0); put(8'h00, 1, 0, 0);

        // R2: disarm after arm, mid-command disarm, re-arm mid-command
        ctl(0); ctl(1);
        put(8'h0B, 1, 0, 0); put(8'h00, 3, 0, 0); put(8'h00, 1, 0, 0);
        ctl(0);
        put(8'h6B, 1, 0, 0); put(8'h00, 3, 0, 0);
        ctl(1);
        put(8'h00, 1, 0, 0); put(8'h00, 1, 0, 0);
        ctl(0);
        put(8'h6C, 1, 0, 0);
        ctl(0);
        put(8'h03, 1, 0, 0); put(8'h00, 3, 0, 0); put(8'h00, 1, 0, 0);
        ctl(0);
        put(8'hBB, 1, 0, 0);
        ctl(0);
        put(8'hEC, 2, 0, 0); put(8'h00, 2, 0, 0); put(8'h00, 1, 1, 3*DPU);
        drain();

        // R8: abort injection with a disarm after 5 bytes
        dummy_data = 8'hC3;
        ctl(0);
        put(8'hBB, 1, 0, 0); put(8'h00, 3, 0, 0);
        put(8'h00, 1, 1, 5);
        repeat (3) @(posedge clk);
        ctl(1);
        put(8'h0B, 1, 0, 0); put(8'h00, 4, 0, 0); // R8 off after abort

        // R8: abort by arm, then new command tracked
        ctl(0);
        put(8'hEB, 1, 0, 0); put(8'h00, 3, 0, 0);
        put(8'h00, 1, 1, 5);
        repeat (3) @(posedge clk);
        ctl(0);
        put(8'h0B, 1, 0, 0); put(8'h00, 3, 0, 0); put(8'h00, 1, 1, DPU);
        drain();

        repeat (5) @(posedge clk);
        check(exp_cons.size() == 0, "R6 pending writes", exp_cons.size(), 0);
        check(exp_run.size() == 0, "R7 pending runs", exp_run.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule